// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Logic

This block produces the two port-to-port interrupt flags for a shared memory with two independent access ports, called port A and port B. The two highest addresses of the memory serve as mailboxes, and each mailbox carries traffic in one direction only. Port A writes the top address to signal port B. Port B writes the address just below it to signal port A. Each flag is active low. The interrupted port clears its own flag by reading its own mailbox address.

The block watches each port's address, chip-enable, write-enable and output-enable strobes, all active low. It samples them on the rising clock edge and updates the flags one cycle later. It stores no data, performs no arbitration and models no open-drain behaviour.

Top module: `mbox_irq`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, both `irq_a_n` and `irq_b_n` are high. Accesses made during reset have no effect.
- R2: A port A write drives `irq_b_n` low from the next cycle. A write means `a_ce_n`=0 and `a_we_n`=0, and it must target the top address (all ones, 0x7FF at the default width).
- R3: A port B read clears `irq_b_n` (high) from the next cycle. A read means `b_ce_n`=0, `b_oe_n`=0 and `b_we_n`=1, and it must target the top address.
- R4: A port B write to the address one below the top (0x7FE at the default width) drives `irq_a_n` low from the next cycle.
- R5: A port A read of the address one below the top clears `irq_a_n` (high) from the next cycle.
- R6: A clear needs all three read strobes in the read state. A mailbox access with chip enable high, output enable high or write enable low does not clear the flag.
- R7: A flag keeps its value in every other case. This covers accesses to any other address, a port writing its own mailbox, a port reading the other port's mailbox, and writes with chip enable or write enable high.
- R8: When a set and a clear of the same flag arrive in the same cycle, the flag goes low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| a_addr | input | ADDR_W | Port A address |
| a_ce_n | input | 1 | Port A chip enable, active low |
| a_we_n | input | 1 | Port A write enable, active low |
| a_oe_n | input | 1 | Port A output enable, active low |
| b_addr | input | ADDR_W | Port B address |
| b_ce_n | input | 1 | Port B chip enable, active low |
| b_we_n | input | 1 | Port B write enable, active low |
| b_oe_n | input | 1 | Port B output enable, active low |
| irq_a_n | output | 1 | Interrupt to port A, active low |
| irq_b_n | output | 1 | Interrupt to port B, active low |

## Verification
The hardest situation to reach from the ports is a set and a clear of one flag in the same cycle while that flag is already in a known state. It needs both ports aimed at the same mailbox, one writing and the other reading. The bench reaches it with two preparation cycles before every stimulus cycle. The first clears both flags with qualified reads. The second optionally sets each flag. The stimulus cycle then sweeps every combination of the three strobes on both ports against four addresses per port, from all four starting flag states.

// File: rtl/mbox_irq.sv
module mbox_irq #(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic              a_ce_n,
  input  logic              a_we_n,
  input  logic              a_oe_n,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic              b_ce_n,
  input  logic              b_we_n,
  input  logic              b_oe_n,
  output logic              irq_a_n,
  output logic              irq_b_n
);
  localparam logic [ADDR_W-1:0] BOX_TO_B = '1;
  localparam logic [ADDR_W-1:0] BOX_TO_A = BOX_TO_B - 1'b1;

  logic a_wr, a_rd, b_wr, b_rd;
  logic set_a, clr_a, set_b, clr_b;

  assign a_wr = !a_ce_n && !a_we_n;
  assign a_rd = !a_ce_n && !a_oe_n && a_we_n;
  assign b_wr = !b_ce_n && !b_we_n;
  assign b_rd = !b_ce_n && !b_oe_n && b_we_n;

  assign set_b = a_wr && (a_addr == BOX_TO_B);
  assign clr_b = b_rd && (b_addr == BOX_TO_B);
  assign set_a = b_wr && (b_addr == BOX_TO_A);
  assign clr_a = a_rd && (a_addr == BOX_TO_A);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_a_n <= 1'b1;
      irq_b_n <= 1'b1;
    end else begin
      if (set_a)      irq_a_n <= 1'b0;
      else if (clr_a) irq_a_n <= 1'b1;
      if (set_b)      irq_b_n <= 1'b0;
      else if (clr_b) irq_b_n <= 1'b1;
    end
  end
endmodule

// File: rtl/mbox_irq_chk.sv
module mbox_irq_chk #(
  parameter int ADDR_W = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] a_addr,
  input logic              a_ce_n,
  input logic              a_we_n,
  input logic              a_oe_n,
  input logic [ADDR_W-1:0] b_addr,
  input logic              b_ce_n,
  input logic              b_we_n,
  input logic              b_oe_n,
  input logic              irq_a_n,
  input logic              irq_b_n
);
  localparam logic [ADDR_W-1:0] TOP = '1;
  localparam logic [ADDR_W-1:0] NXT = TOP - 1'b1;

  logic wr_b_box, rd_b_box, wr_a_box, rd_a_box;
  assign wr_b_box = !a_ce_n && !a_we_n && a_addr == TOP;
  assign rd_b_box = !b_ce_n && !b_oe_n && b_we_n && b_addr == TOP;
  assign wr_a_box = !b_ce_n && !b_we_n && b_addr == NXT;
  assign rd_a_box = !a_ce_n && !a_oe_n && a_we_n && a_addr == NXT;

  p_reset_r1: assert property (@(posedge clk) !rst_n |=> (irq_a_n && irq_b_n));
  p_set_b_r2: assert property (@(posedge clk) disable iff (!rst_n) wr_b_box |=> !irq_b_n);
  p_clr_b_r3: assert property (@(posedge clk) disable iff (!rst_n) (rd_b_box && !wr_b_box) |=> irq_b_n);
  p_set_a_r4: assert property (@(posedge clk) disable iff (!rst_n) wr_a_box |=> !irq_a_n);
  p_clr_a_r5: assert property (@(posedge clk) disable iff (!rst_n) (rd_a_box && !wr_a_box) |=> irq_a_n);
  p_no_oe_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (a_oe_n && !wr_a_box) |=> $stable(irq_a_n));
  p_hold_a_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_a_box && !rd_a_box) |=> $stable(irq_a_n));
  p_hold_b_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_b_box && !rd_b_box) |=> $stable(irq_b_n));
  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_b_box && rd_b_box) |=> !irq_b_n);
endmodule

bind mbox_irq mbox_irq_chk #(.ADDR_W(ADDR_W)) chk (
  .clk(clk), .rst_n(rst_n),
  .a_addr(a_addr), .a_ce_n(a_ce_n), .a_we_n(a_we_n), .a_oe_n(a_oe_n),
  .b_addr(b_addr), .b_ce_n(b_ce_n), .b_we_n(b_we_n), .b_oe_n(b_oe_n),
  .irq_a_n(irq_a_n), .irq_b_n(irq_b_n)
);

// File: tb/mbox_irq_test.sv
module mbox_irq_test;
  localparam int AW = 11;
  localparam logic [AW-1:0] TOP = 11'h7FF;
  localparam logic [AW-1:0] NXT = 11'h7FE;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] a_addr = '0, b_addr = '0;
  logic a_ce_n = 1'b1, a_we_n = 1'b1, a_oe_n = 1'b1;
  logic b_ce_n = 1'b1, b_we_n = 1'b1, b_oe_n = 1'b1;
  logic irq_a_n, irq_b_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  mbox_irq #(.ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n),
    .a_addr(a_addr), .a_ce_n(a_ce_n), .a_we_n(a_we_n), .a_oe_n(a_oe_n),
    .b_addr(b_addr), .b_ce_n(b_ce_n), .b_we_n(b_we_n), .b_oe_n(b_oe_n),
    .irq_a_n(irq_a_n), .irq_b_n(irq_b_n)
  );

  function automatic logic [AW-1:0] pick(int k);
    case (k)
      0: return TOP;
      1: return NXT;
      2: return 11'h3FF;
      default: return 11'h7FD;
    endcase
  endfunction

  task automatic check(string tag, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: got %b expected %b", tag, what, act, exp);
    end
  endtask

  task automatic idle();
    a_ce_n = 1; a_we_n = 1; a_oe_n = 1;
    b_ce_n = 1; b_we_n = 1; b_oe_n = 1;
    a_addr = '0; b_addr = '0;
  endtask

  task automatic run_case(bit low_a, bit low_b, logic [2:0] sa, logic [2:0] sb,
                          logic [AW-1:0] aa, logic [AW-1:0] ab);
    bit aw, ar, bw, br, s_a, c_a, s_b, c_b;
    logic ea, eb;
    string ta, tb;
    // prep 1: clear both with qualified reads
    @(negedge clk);
    a_ce_n = 0; a_oe_n = 0; a_we_n = 1; a_addr = NXT;
    b_ce_n = 0; b_oe_n = 0; b_we_n = 1; b_addr = TOP;
    // prep 2: set the requested flags
    @(negedge clk);
    idle();
    if (low_b) begin a_ce_n = 0; a_we_n = 0; a_addr = TOP; end
    if (low_a) begin b_ce_n = 0; b_we_n = 0; b_addr = NXT; end
    // stimulus: strobes packed as {ce_n, we_n, oe_n}
    @(negedge clk);
    {a_ce_n, a_we_n, a_oe_n} = sa; a_addr = aa;
    {b_ce_n, b_we_n, b_oe_n} = sb; b_addr = ab;
    aw = !sa[2] && !sa[1];
    ar = !sa[2] && sa[1] && !sa[0];
    bw = !sb[2] && !sb[1];
    br = !sb[2] && sb[1] && !sb[0];
    s_b = aw && aa == TOP; c_b = br && ab == TOP;
    s_a = bw && ab == NXT; c_a = ar && aa == NXT;
    ea = s_a ? 1'b0 : (c_a ? 1'b1 : !low_a);
    eb = s_b ? 1'b0 : (c_b ? 1'b1 : !low_b);
    ta = (s_a && c_a) ? "R8" : s_a ? "R4" : c_a ? "R5" :
         (aa == NXT && !sa[2]) ? "R6" : "R7";
    tb = (s_b && c_b) ? "R8" : s_b ? "R2" : c_b ? "R3" :
         (ab == TOP && !sb[2]) ? "R6" : "R7";
    @(negedge clk);
    idle();
    check(ta, "irq_a_n", irq_a_n, ea);
    check(tb, "irq_b_n", irq_b_n, eb);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    idle();
    // R1: reset state, accesses during reset ignored
    @(negedge clk);
    a_ce_n = 0; a_we_n = 0; a_addr = TOP;
    b_ce_n = 0; b_we_n = 0; b_addr = NXT;
    @(negedge clk);
    check("R1", "irq_a_n in reset", irq_a_n, 1'b1);
    check("R1", "irq_b_n in reset", irq_b_n, 1'b1);
    idle();
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "irq_a_n after reset", irq_a_n, 1'b1);
    check("R1", "irq_b_n after reset", irq_b_n, 1'b1);

    for (int st = 0; st < 4; st++)
      for (int sa = 0; sa < 8; sa++)
        for (int sb = 0; sb < 8; sb++)
          for (int ka = 0; ka < 4; ka++)
            for (int kb = 0; kb < 4; kb++)
              run_case(st[0], st[1], 3'(sa), 3'(sb), pick(ka), pick(kb));

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule